// File: doc/BRIEF.md
# Channel-Gain Queue Acquisition Controller

This block is the register front end of a 12-bit, eight-input sampling subsystem. A host programs a short list of (channel, gain) pairs through a byte-wide register bus. Each conversion trigger sends the current list entry to the converter and moves on to the next entry. When the list ends, scanning goes back to the start. The conversion trigger can be a software write, a pacer tick or an external edge. Each finished result is tagged with the channel it belongs to and stored in a sample FIFO. The host reads the FIFO one 16-bit word at a time.

The block raises a data-ready flag, and an interrupt when interrupts are enabled. A conversion that finds the FIFO full sets a sticky overrun flag. A list that the converter's input multiplexing cannot scan is flagged as a configuration error, and while that flag is set no conversion starts.

Top module: `acq_queue_ctrl`

## Requirements
- R1: After reset, `irq` and `adc_start` are low. The status register (offset 2), the interrupt control register (offset 5) and the sample port (offset 0, FIFO empty) all read 0.
- R2: A byte written to offset 7 is stored at the list index last written to offset 6. That byte's bits [2:0] are the channel and bits [7:4] are the gain. The list length is the highest index written plus one. Writing 0 to offset 6 starts a new, empty list. An empty list behaves as a one-entry list at index 0. At each start, `adc_chan` and `adc_gain` carry the fields of the current entry.
- R3: Each started conversion moves the scan position forward by one entry. After the last entry the position returns to index 0. A write to offset 6 resets the position to 0.
- R4: A 16-bit read at offset 0 removes the oldest sample. The word holds the 12-bit result in bits [15:4], 0 in bit 3 and the channel in bits [2:0]. Samples come out in conversion order. A read of an empty FIFO returns 0.
- R5: A write of any value to offset 0 starts one conversion. `adc_start` is high for exactly the one cycle after the write cycle.
- R6: Bits [1:0] of the interrupt control register pick the hardware trigger. Value 3 starts a conversion on each `pacer_tick`. Value 2 starts one on each rising edge of `ext_trig`. Any other value makes both inputs ignored.
- R7: When status bit 0 has been written to 1, hardware triggers are blocked until `ext_trig` shows a rising edge. That first edge only opens the gate and starts no conversion. Writing the status register closes the gate again.
- R8: A trigger that arrives between a start and its `adc_done` is ignored. It causes no start and no scan advance.
- R9: Status bit 1 reports a configuration error. It is set when the list length is at least 2 and either the length is odd or some entry's channel parity differs from its index parity. While the flag is set, every trigger is ignored.
- R10: The FIFO holds 1024 samples. A result that arrives while the FIFO is full is dropped and sets status bit 5. Bit 5 stays set until a write to offset 4.
- R11: Status bit 7 (data ready) is set by each `adc_done` while interrupt-enable (bit 7 at offset 5) is 1. `irq` is bit 7 ANDed with the enable. A write to offset 4 clears bits 7 and 5. An `adc_done` in the same cycle as that write takes precedence over the clear.
- R12: Offset 5 reads back the whole byte last written to it, including the 3-bit line select in bits [6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; at offset 0 it removes one sample |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 3 | Channel of the requested conversion |
| adc_gain | output | 4 | Gain code of the requested conversion |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 12 | Conversion result |
| pacer_tick | input | 1 | Internal pacer tick |
| ext_trig | input | 1 | External trigger level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the converter returns exactly one `adc_done` for each `adc_start`, at least one cycle after it, and never sends a spontaneous `adc_done`. They also assume the host raises at most one of `bus_wr` and `bus_rd` in a given cycle. The bench's converter model follows these rules: it replies to each start after a fixed delay, and its bus tasks issue one access at a time, separated by idle cycles. Pacer ticks and external edges are generated only while the bench knows whether a conversion is still outstanding, so every expected start and every ignored trigger can be predicted in advance.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int RES_W  = 12;
    localparam int CHAN_W = 3;
    localparam int GAIN_W = 4;

    // Register offsets seen by the host
    localparam logic [3:0] OFS_SAMPLE = 4'd0;
    localparam logic [3:0] OFS_STATUS = 4'd2;
    localparam logic [3:0] OFS_CLEAR  = 4'd4;
    localparam logic [3:0] OFS_ICR    = 4'd5;
    localparam logic [3:0] OFS_QADDR  = 4'd6;
    localparam logic [3:0] OFS_QDATA  = 4'd7;

    // Hardware trigger source codes in the interrupt control byte
    localparam logic [1:0] SRC_EXT   = 2'd2;
    localparam logic [1:0] SRC_TIMER = 2'd3;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CHAN_W-1:0] chan;
    } qent_t;

    typedef struct packed {
        logic       ie;
        logic [2:0] line;
        logic [1:0] spare;
        logic [1:0] src;
    } icr_t;

    function automatic qent_t unpack_qbyte(input logic [7:0] b);
        qent_t e;
        e.gain = b[7:4];
        e.chan = b[2:0];
        return e;
    endfunction

    function automatic logic [15:0] make_word(input logic [RES_W-1:0] r,
                                              input logic [CHAN_W-1:0] c);
        return {r, 1'b0, c};
    endfunction

    function automatic logic [7:0] status_byte(input logic rdy, input logic ovr,
                                               input logic err, input logic arm);
        return {rdy, 1'b0, ovr, 3'b000, err, arm};
    endfunction

endpackage

// File: rtl/acq_chan_queue.sv
module acq_chan_queue
    import acq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic          data_we,
    input  logic [7:0]    wbyte,
    input  logic          advance,
    output qent_t         cur,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] scan_ptr,
    output logic [AW:0]   len,
    output logic          cfg_err
);

    qent_t       mem [DEPTH];
    logic        bad;
    logic [AW:0] eff_len;
    logic [AW:0] addr_p1;
    logic [AW:0] ptr_p1;

    assign eff_len = (len == '0) ? (AW+1)'(1) : len;
    assign addr_p1 = {1'b0, wr_addr} + (AW+1)'(1);
    assign ptr_p1  = {1'b0, scan_ptr} + (AW+1)'(1);
    assign cur     = mem[scan_ptr];
    assign cfg_err = (len >= (AW+1)'(2)) && (bad || len[0]);

    always_ff @(posedge clk) begin
        if (data_we) mem[wr_addr] <= unpack_qbyte(wbyte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr  <= '0;
            scan_ptr <= '0;
            len      <= '0;
            bad      <= 1'b0;
        end else begin
            if (addr_we) begin
                wr_addr <= wbyte[AW-1:0];
                if (wbyte == 8'd0) begin
                    len <= '0;
                    bad <= 1'b0;
                end
            end
            if (data_we) begin
                if (addr_p1 > len) len <= addr_p1;
                if (wbyte[0] != wr_addr[0]) bad <= 1'b1;
            end
            if (addr_we)
                scan_ptr <= '0;
            else if (advance)
                scan_ptr <= (ptr_p1 >= eff_len) ? '0 : ptr_p1[AW-1:0];
        end
    end

endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
    parameter  int DEPTH = 1024,
    parameter  int W     = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/acq_queue_ctrl.sv
module acq_queue_ctrl
    import acq_pkg::*;
#(
    parameter int FIFO_DEPTH  = 1024,
    parameter int QUEUE_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [15:0] bus_rdata,
    output logic        adc_start,
    output logic [2:0]  adc_chan,
    output logic [3:0]  adc_gain,
    input  logic        adc_done,
    input  logic [11:0] adc_data,
    input  logic        pacer_tick,
    input  logic        ext_trig,
    output logic        irq
);

    localparam int QAW = $clog2(QUEUE_DEPTH);
    localparam int CW  = $clog2(FIFO_DEPTH) + 1;

    icr_t           icr;
    logic           arm, gate_open, rdy_q, ovr_q, busy, ext_prev;
    logic [2:0]     tag_q;
    qent_t          cur;
    logic [QAW-1:0] q_wr_addr, scan_ptr;
    logic [QAW:0]   q_len;
    logic           cfg_err;
    logic [15:0]    fifo_dout;
    logic           fifo_empty, fifo_full;
    logic [CW-1:0]  fifo_cnt;

    logic wr_sample, wr_status, wr_clear, wr_icr, wr_qaddr, wr_qdata, rd_sample;
    logic ext_rise, hw_ok, hw_trig, trig;

    assign wr_sample = bus_wr && (bus_addr == OFS_SAMPLE);
    assign wr_status = bus_wr && (bus_addr == OFS_STATUS);
    assign wr_clear  = bus_wr && (bus_addr == OFS_CLEAR);
    assign wr_icr    = bus_wr && (bus_addr == OFS_ICR);
    assign wr_qaddr  = bus_wr && (bus_addr == OFS_QADDR);
    assign wr_qdata  = bus_wr && (bus_addr == OFS_QDATA);
    assign rd_sample = bus_rd && (bus_addr == OFS_SAMPLE);

    assign ext_rise = ext_trig && !ext_prev;
    assign hw_ok    = !arm || gate_open;
    assign hw_trig  = hw_ok && (((icr.src == SRC_TIMER) && pacer_tick) ||
                                ((icr.src == SRC_EXT) && ext_rise));
    assign trig     = (wr_sample || hw_trig) && !busy && !cfg_err;

    acq_chan_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .addr_we  (wr_qaddr),
        .data_we  (wr_qdata),
        .wbyte    (bus_wdata),
        .advance  (trig),
        .cur      (cur),
        .wr_addr  (q_wr_addr),
        .scan_ptr (scan_ptr),
        .len      (q_len),
        .cfg_err  (cfg_err)
    );

    acq_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(16)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (adc_done),
        .din   (make_word(adc_data, tag_q)),
        .pop   (rd_sample),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            icr       <= '0;
            arm       <= 1'b0;
            gate_open <= 1'b0;
            rdy_q     <= 1'b0;
            ovr_q     <= 1'b0;
            busy      <= 1'b0;
            ext_prev  <= 1'b0;
            tag_q     <= '0;
            adc_start <= 1'b0;
            adc_chan  <= '0;
            adc_gain  <= '0;
        end else begin
            ext_prev  <= ext_trig;
            adc_start <= trig;
            if (wr_icr) icr <= icr_t'(bus_wdata);
            if (wr_status) begin
                arm       <= bus_wdata[0];
                gate_open <= 1'b0;
            end else if (arm && ext_rise) begin
                gate_open <= 1'b1;
            end
            if (trig) begin
                busy     <= 1'b1;
                adc_chan <= cur.chan;
                adc_gain <= cur.gain;
                tag_q    <= cur.chan;
            end else if (adc_done) begin
                busy <= 1'b0;
            end
            if (wr_clear) begin
                rdy_q <= 1'b0;
                ovr_q <= 1'b0;
            end
            // A completion in the clear cycle is reported, not lost
            if (adc_done) begin
                if (icr.ie)    rdy_q <= 1'b1;
                if (fifo_full) ovr_q <= 1'b1;
            end
        end
    end

    assign irq = rdy_q && icr.ie;

    always_comb begin
        case (bus_addr)
            OFS_SAMPLE: bus_rdata = fifo_empty ? 16'd0 : fifo_dout;
            OFS_STATUS: bus_rdata = {8'd0, status_byte(rdy_q, ovr_q, cfg_err, arm)};
            OFS_ICR:    bus_rdata = {8'd0, icr};
            OFS_QADDR:  bus_rdata = 16'(q_wr_addr);
            default:    bus_rdata = 16'd0;
        endcase
    end

endmodule

// File: rtl/acq_queue_ctrl_chk.sv
module acq_queue_ctrl_chk #(
    parameter int FIFO_DEPTH = 1024,
    parameter int QAW        = 4,
    parameter int CW         = 11
) (
    input logic           clk,
    input logic           rst,
    input logic [3:0]     bus_addr,
    input logic           bus_wr,
    input logic           adc_start,
    input logic           adc_done,
    input logic           irq,
    input logic           cfg_err,
    input logic           ovr,
    input logic [CW-1:0]  fifo_cnt,
    input logic [QAW-1:0] scan_ptr,
    input logic [QAW:0]   q_len
);

    p_refuse_start_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !adc_start);

    p_single_start_r8: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(bus_wr && bus_addr == 4'd4)) |=> ovr);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(FIFO_DEPTH));

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd4 && !adc_done) |=> !irq);

    p_scan_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (scan_ptr == '0) || ({1'b0, scan_ptr} < q_len));

endmodule

bind acq_queue_ctrl acq_queue_ctrl_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .QAW        ($clog2(QUEUE_DEPTH)),
    .CW         ($clog2(FIFO_DEPTH) + 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .irq       (irq),
    .cfg_err   (cfg_err),
    .ovr       (ovr_q),
    .fifo_cnt  (fifo_cnt),
    .scan_ptr  (scan_ptr),
    .q_len     (q_len)
);

// File: tb/tb_acq_queue_ctrl.sv
`timescale 1ns/100ps
module tb_acq_queue_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        adc_start;
    logic [2:0]  adc_chan;
    logic [3:0]  adc_gain;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic        pacer_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    acq_queue_ctrl dut (.*);

    int n_chk = 0, n_fail = 0, starts = 0;
    logic [2:0]  m_chan [16];
    logic [3:0]  m_gain [16];
    int          m_len = 1, m_idx = 0, m_cnt = 0;
    logic [11:0] next_val = 12'h5A0;
    logic [6:0]  start_q [$];
    logic [15:0] exp_words [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Program list entries into the design and into the bench model
    task automatic load_list(input int n);
        wr(4'd6, 8'd0);
        for (int i = 0; i < n; i++) begin
            wr(4'd6, 8'(i));
            wr(4'd7, {m_gain[i], 1'b0, m_chan[i]});
        end
        m_len = n; m_idx = 0;
    endtask

    // Driver side of the scoreboard: one accepted conversion
    task automatic expect_conv();
        start_q.push_back({m_gain[m_idx], m_chan[m_idx]});
        if (m_cnt < 1024) begin
            exp_words.push_back({next_val, 1'b0, m_chan[m_idx]});
            m_cnt++;
        end
        m_idx = (m_idx + 1) % ((m_len == 0) ? 1 : m_len);
    endtask

    task automatic sw_conv();
        expect_conv();
        wr(4'd0, 8'h55);
        idle(8);
    endtask

    task automatic read_check(input string req);
        logic [15:0] v, e;
        rd(4'd0, v);
        e = exp_words.pop_front();
        m_cnt--;
        check(v == e, req, v, e);
    endtask

    task automatic tick();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_trig = 1'b1;
        idle(2); ext_trig = 1'b0;
    endtask

    // Monitor: compare each start against the expected list entry
    initial forever begin
        @(negedge clk);
        if (adc_start) begin
            starts++;
            if (start_q.size() == 0) begin
                check(1'b0, "R8 unexpected start", 1, 0);
            end else begin
                logic [6:0] e;
                e = start_q.pop_front();
                check({adc_gain, adc_chan} == e, "R2 R3 start entry",
                      {adc_gain, adc_chan}, e);
            end
        end
    end

    // Converter model: fixed latency, values from next_val
    initial forever begin
        @(negedge clk);
        if (adc_start) begin
            idle(3);
            adc_data = next_val; adc_done = 1'b1;
            @(negedge clk); adc_done = 1'b0;
            next_val = next_val + 12'd1;
        end
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int s0;
        idle(4); rst = 1'b0; idle(2);

        // R1 reset state
        rd(4'd2, v); check(v == 16'd0, "R1 status", v, 0);
        rd(4'd5, v); check(v == 16'd0, "R1 icr", v, 0);
        rd(4'd0, v); check(v == 16'd0, "R1 sample port", v, 0);
        check(!irq && !adc_start, "R1 irq/start", {irq, adc_start}, 0);

        // R12 readback
        wr(4'd5, 8'hF3); rd(4'd5, v); check(v == 16'h00F3, "R12 icr", v, 16'hF3);
        wr(4'd5, 8'hA0); rd(4'd5, v); check(v == 16'h00A0, "R12 icr", v, 16'hA0);

        // R2 R5 R11 R4 single entry, software start
        m_chan[0] = 3'd3; m_gain[0] = 4'd5;
        load_list(1);
        s0 = starts;
        sw_conv();
        check(starts == s0 + 1, "R5 one start", starts - s0, 1);
        rd(4'd2, v); check(v[7] == 1'b1, "R11 ready flag", v, 16'h80);
        check(irq == 1'b1, "R11 irq", irq, 1);
        read_check("R4 sample word");
        rd(4'd0, v); check(v == 16'd0, "R4 empty read", v, 0);
        wr(4'd4, 8'h00);
        rd(4'd2, v); check(v[7] == 1'b0, "R11 clear", v, 0);
        check(irq == 1'b0, "R11 irq cleared", irq, 0);

        // R3 four-entry list with wrap
        for (int i = 0; i < 4; i++) begin m_chan[i] = 3'(i); m_gain[i] = 4'(i + 8); end
        load_list(4);
        rd(4'd2, v); check(v[1] == 1'b0, "R9 legal list", v, 0);
        for (int i = 0; i < 6; i++) sw_conv();
        for (int i = 0; i < 6; i++) read_check("R3 R4 scan order");

        // R9 parity violation and odd length
        m_chan[0] = 3'd0; m_gain[0] = 4'd0; m_chan[1] = 3'd2; m_gain[1] = 4'd0;
        load_list(2);
        rd(4'd2, v); check(v[1] == 1'b1, "R9 parity error", v, 2);
        s0 = starts; wr(4'd0, 8'h00); idle(8);
        check(starts == s0, "R9 start refused", starts - s0, 0);
        m_chan[1] = 3'd1; m_chan[2] = 3'd2; m_gain[2] = 4'd0;
        load_list(3);
        rd(4'd2, v); check(v[1] == 1'b1, "R9 odd length", v, 2);
        m_chan[0] = 3'd5; m_gain[0] = 4'd3;
        load_list(1);
        rd(4'd2, v); check(v[1] == 1'b0, "R9 single entry ok", v, 0);

        // R6 hardware trigger selection
        m_chan[0] = 3'd4; m_gain[0] = 4'd1; m_chan[1] = 3'd7; m_gain[1] = 4'd2;
        load_list(2);
        wr(4'd5, 8'h83);
        s0 = starts; expect_conv(); tick(); idle(8);
        check(starts == s0 + 1, "R6 pacer start", starts - s0, 1);
        s0 = starts; ext_pulse(); idle(8);
        check(starts == s0, "R6 ext ignored in timer mode", starts - s0, 0);
        wr(4'd5, 8'h82);
        s0 = starts; tick(); idle(8);
        check(starts == s0, "R6 tick ignored in ext mode", starts - s0, 0);
        expect_conv(); ext_pulse(); idle(8);
        check(starts == s0 + 1, "R6 ext start", starts - s0, 1);
        wr(4'd5, 8'h80);
        s0 = starts; tick(); ext_pulse(); idle(8);
        check(starts == s0, "R6 no source", starts - s0, 0);

        // R7 armed external start gate
        wr(4'd5, 8'h83); wr(4'd2, 8'h01);
        rd(4'd2, v); check(v[0] == 1'b1, "R7 arm bit", v, 1);
        s0 = starts; tick(); idle(8);
        check(starts == s0, "R7 gated", starts - s0, 0);
        ext_pulse(); idle(8);
        check(starts == s0, "R7 opening edge", starts - s0, 0);
        expect_conv(); tick(); idle(8);
        check(starts == s0 + 1, "R7 gate open", starts - s0, 1);
        wr(4'd2, 8'h00); wr(4'd5, 8'hA0);

        // R8 trigger while busy
        s0 = starts; expect_conv();
        wr(4'd0, 8'h01); wr(4'd0, 8'h02); idle(8);
        check(starts == s0 + 1, "R8 busy trigger ignored", starts - s0, 1);
        expect_conv(); wr(4'd0, 8'h03); idle(8);
        while (exp_words.size() > 0) read_check("R8 R4 drain");
        wr(4'd4, 8'h00);

        // R11 no flag with interrupts disabled, R10 overrun
        wr(4'd5, 8'h00);
        m_chan[0] = 3'd5; m_gain[0] = 4'd2;
        load_list(1);
        for (int i = 0; i < 1025; i++) sw_conv();
        rd(4'd2, v); check(v[5] == 1'b1, "R10 overrun set", v, 16'h20);
        check(v[7] == 1'b0 && !irq, "R11 no flag when disabled", v, 0);
        wr(4'd5, 8'h10);
        rd(4'd2, v); check(v[5] == 1'b1, "R10 overrun sticky", v, 16'h20);
        for (int i = 0; i < 1024; i++) read_check("R10 fifo contents");
        rd(4'd0, v); check(v == 16'd0, "R10 R4 empty after drain", v, 0);
        wr(4'd4, 8'h00);
        rd(4'd2, v); check(v[5] == 1'b0, "R10 overrun cleared", v, 0);

        idle(4);
        summary();
        $finish;
    end

endmodule